// File: doc/BRIEF.md
# Multi-Error Correction Sequencer

This block runs the correction step that follows the read of one 512-byte chunk protected by a four-error-correcting code. A host writes the eight expected 10-bit check values into it one per cycle. The host feeds them in reverse order: slot 7 first and slot 0 last. The syndrome engine supplies the eight check values it computed over the data it read. The block XORs each expected value with its computed value to form four syndrome words. When a start pulse arrives, it decides whether any syndrome bit is set. A clean chunk settles at once. Otherwise the sequencer launches the error-location search. That search is modelled here as a fixed-latency black box whose results the environment injects at start.

A 4-bit state code is visible at all times. It shows a brief transient, then a stepping "working" code during the search, then a settled outcome. For a correctable chunk the block walks the reported error entries one per cycle. It turns each raw 10-bit location into a byte offset and XORs the error value into the data buffer through a write port. Locations that land outside the data area are skipped without being counted. When all entries are walked, the block raises done and reports how many bytes it changed. The first check value of the next chunk clears the results.

Top module: `ecc4_fix_seq`

## Requirements
- R1: Check values are stored by a slot pointer that starts at 7 after reset, steps down by one on each accepted load and wraps from 0 back to 7. Loads and start pulses that arrive while the block is busy (state codes 3 during the decision cycle, 4 to 7, or 2) are ignored.
- R2: The block forms syndrome word w from two XORs of an expected value with its computed value. Bits 0..9 hold the XOR for slot 2w and bits 16..25 hold the XOR for slot 2w+1. `calc_chk` carries slot k in bits [10k+9:10k]. If all four words are zero, the cycle after the decision shows state code 0 with done high, and no buffer write occurs.
- R3: In the cycle after a start is accepted, the state code reads 3 and done is low, before any processing has happened.
- R4: A non-zero syndrome starts a search that lasts SRCH_LAT cycles. During cycle k of the search (counting from 0), the state code is 4 + (k mod 4).
- R5: If the injected outcome is uncorrectable, the block settles with state code 1, done high, a corrected count of 0 and no buffer writes.
- R6: The error-count output equals the injected 2-bit field, and field+1 entries are processed. Entry 0 is taken from pair A bits [9:0] (address) and [7:0] (value). Entry 1 comes from pair A bits [25:16] and [23:16]. Entries 2 and 3 use the same bit positions in pair B.
- R7: While entries are applied, the state code is 2 and one entry is handled per cycle. The byte offset is 519 minus the raw address. An offset in 0..511 produces one write pulse at that offset, with the entry value as the XOR mask.
- R8: An entry whose offset falls outside 0..511 causes no write and is not counted.
- R9: After the last entry, the block settles with state code 3 and done high. The corrected count then equals the number of writes issued.
- R10: After reset, or when a load into slot 7 is accepted while no start is present, the block shows state code 0 with done low, a corrected count of 0 and an error count of 0.
- R11: A start accepted while results are settled begins a new decision using the values already stored.
- R12: A load that arrives in the same cycle as an accepted start is included in the syndrome that start decides on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | One expected check value is present |
| ld_chk | input | 10 | Expected check value for the current slot |
| calc_chk | input | 80 | Eight computed check values, slot k in bits [10k+9:10k] |
| start | input | 1 | Start-correction pulse |
| loc_uncorr | input | 1 | Injected search result: five or more errors |
| loc_cnt_fld | input | 2 | Injected error-count field (entries minus one) |
| loc_addr_a | input | 32 | Injected location pair A (entries 0 and 1) |
| loc_addr_b | input | 32 | Injected location pair B (entries 2 and 3) |
| loc_val_a | input | 32 | Injected error values for entries 0 and 1 |
| loc_val_b | input | 32 | Injected error values for entries 2 and 3 |
| st_code | output | 4 | State code nibble |
| err_fld | output | 2 | Error-count field of the current result |
| fix_cnt | output | 3 | Bytes actually corrected |
| done | output | 1 | Result settled |
| buf_we | output | 1 | Buffer XOR-write strobe |
| buf_addr | output | 9 | Byte offset of the write |
| buf_mask | output | 8 | XOR mask for the write |

## Verification
Two events can meet in one cycle: the final check value for slot 0 and the start pulse that decides on it. The bench makes the syndrome non-zero only through that last value and raises start in the same cycle. If the block missed the value, it would settle clean with code 0. A correct block must instead search and correct. A second collision comes from a start pulse and a stray load driven together in the middle of a search. Here the state code must keep stepping, and the very next chunk's first load must still clear the results. That second check shows that the slot pointer did not move.

// File: rtl/ecc4_fix_pkg.sv
package ecc4_fix_pkg;

    // Fixed layout of the location/value registers
    localparam int RAW_W  = 10;
    localparam int HALF_W = 16;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] CODE_CLEAN   = 4'd0;
    localparam logic [CODE_W-1:0] CODE_UNCORR  = 4'd1;
    localparam logic [CODE_W-1:0] CODE_APPLY   = 4'd2;
    localparam logic [CODE_W-1:0] CODE_SETTLED = 4'd3;
    localparam logic [CODE_W-1:0] CODE_WORK    = 4'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_SEARCH,
        ST_UNCORR,
        ST_APPLY,
        ST_FIXED,
        ST_CLEAN
    } seq_st_e;

    typedef struct packed {
        logic [RAW_W-1:0]  raw;
        logic [BYTE_W-1:0] val;
    } err_ent_t;

    // Entry select: bit 1 picks the pair, bit 0 picks the half
    function automatic err_ent_t pick_entry(
        input logic [1:0]        idx,
        input logic [WORD_W-1:0] a0,
        input logic [WORD_W-1:0] a1,
        input logic [WORD_W-1:0] v0,
        input logic [WORD_W-1:0] v1
    );
        err_ent_t e;
        logic [WORD_W-1:0] aw;
        logic [WORD_W-1:0] vw;
        aw = idx[1] ? a1 : a0;
        vw = idx[1] ? v1 : v0;
        e.raw = idx[0] ? aw[HALF_W +: RAW_W]  : aw[0 +: RAW_W];
        e.val = idx[0] ? vw[HALF_W +: BYTE_W] : vw[0 +: BYTE_W];
        return e;
    endfunction

endpackage

// File: rtl/ecc4_chk_bank.sv
module ecc4_chk_bank
    import ecc4_fix_pkg::*;
#(
    parameter int N_CHK = 8,
    parameter int CHK_W = RAW_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ld_en,
    input  logic [CHK_W-1:0]       ld_val,
    input  logic [N_CHK*CHK_W-1:0] calc,
    output logic                   first_slot,
    output logic                   syn_zero
);
    localparam int PTR_W  = $clog2(N_CHK);
    localparam int N_WORD = N_CHK / 2;
    localparam logic [PTR_W-1:0] TOP = PTR_W'(N_CHK - 1);

    logic [CHK_W-1:0] exp_q [N_CHK];
    logic [PTR_W-1:0] ptr_q;
    logic [N_WORD-1:0][WORD_W-1:0] syn_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= TOP;
            for (int k = 0; k < N_CHK; k++) exp_q[k] <= '0;
        end else if (ld_en) begin
            exp_q[ptr_q] <= ld_val;
            ptr_q <= (ptr_q == '0) ? TOP : ptr_q - PTR_W'(1);
        end
    end

    generate
        for (genvar w = 0; w < N_WORD; w++) begin : g_word
            logic [CHK_W-1:0] lo;
            logic [CHK_W-1:0] hi;
            assign lo = exp_q[2*w]   ^ calc[(2*w)*CHK_W   +: CHK_W];
            assign hi = exp_q[2*w+1] ^ calc[(2*w+1)*CHK_W +: CHK_W];
            assign syn_w[w] = {{(WORD_W-HALF_W-CHK_W){1'b0}}, hi,
                               {(HALF_W-CHK_W){1'b0}}, lo};
        end
    endgenerate

    assign syn_zero   = ~|syn_w;
    assign first_slot = (ptr_q == TOP);

    // R1: pointer wraps from slot 0 back to the top slot
    a_r1_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
        (ld_en && ptr_q == '0) |=> (ptr_q == TOP));
    // R1: pointer steps down by one per accepted load
    a_r1_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (ld_en && ptr_q != '0) |=> (ptr_q == $past(ptr_q) - PTR_W'(1)));
    // R1: without a load the pointer holds
    a_r1_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        !ld_en |=> $stable(ptr_q));

endmodule

// File: rtl/ecc4_search_model.sv
module ecc4_search_model
    import ecc4_fix_pkg::*;
#(
    parameter int LAT = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    output logic              busy,
    output logic              fin,
    output logic [CODE_W-1:0] phase
);
    localparam int CNT_W = (LAT > 4) ? $clog2(LAT) : 2;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LAT - 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (go) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == LAST) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign busy  = busy_q;
    assign fin   = busy_q && (cnt_q == LAST);
    assign phase = CODE_WORK + {2'b00, cnt_q[1:0]};

    // R4: the search ends after its final cycle
    a_r4_fin_ends: assert property (@(posedge clk) disable iff (rst)
        (fin && !go) |=> !busy_q);
    // R4: the visible code changes every cycle while working
    a_r4_code_steps: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !fin) |=> (busy_q && phase != $past(phase)));

endmodule

// File: rtl/ecc4_entry_apply.sv
module ecc4_entry_apply
    import ecc4_fix_pkg::*;
#(
    parameter int CHUNK_BYTES = 512,
    parameter int OFF_BASE    = 519,
    parameter int ADDR_W      = 9
) (
    input  logic              active,
    input  logic [1:0]        idx,
    input  logic [WORD_W-1:0] a0,
    input  logic [WORD_W-1:0] a1,
    input  logic [WORD_W-1:0] v0,
    input  logic [WORD_W-1:0] v1,
    output logic              hit,
    output logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] mask
);
    err_ent_t ent;
    int       off;

    always_comb begin
        ent  = pick_entry(idx, a0, a1, v0, v1);
        off  = OFF_BASE - int'(ent.raw);
        hit  = active && (off >= 0) && (off < CHUNK_BYTES);
        addr = hit ? ADDR_W'(off) : '0;
        mask = hit ? ent.val : '0;
    end

endmodule

// File: rtl/ecc4_fix_seq.sv
module ecc4_fix_seq
    import ecc4_fix_pkg::*;
#(
    parameter int CHUNK_BYTES = 512,
    parameter int N_CHK       = 8,
    parameter int CHK_W       = 10,
    parameter int SRCH_LAT    = 6
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           ld_valid,
    input  logic [CHK_W-1:0]               ld_chk,
    input  logic [N_CHK*CHK_W-1:0]         calc_chk,
    input  logic                           start,
    input  logic                           loc_uncorr,
    input  logic [1:0]                     loc_cnt_fld,
    input  logic [31:0]                    loc_addr_a,
    input  logic [31:0]                    loc_addr_b,
    input  logic [31:0]                    loc_val_a,
    input  logic [31:0]                    loc_val_b,
    output logic [3:0]                     st_code,
    output logic [1:0]                     err_fld,
    output logic [2:0]                     fix_cnt,
    output logic                           done,
    output logic                           buf_we,
    output logic [$clog2(CHUNK_BYTES)-1:0] buf_addr,
    output logic [7:0]                     buf_mask
);
    localparam int OFF_BASE = CHUNK_BYTES + 7;
    localparam int ADDR_W   = $clog2(CHUNK_BYTES);

    seq_st_e st_q;
    logic [1:0]        idx_q;
    logic [2:0]        fix_q;
    logic [1:0]        fld_q;
    logic              cap_unc_q;
    logic [1:0]        cap_fld_q;
    logic [WORD_W-1:0] cap_a0_q, cap_a1_q, cap_v0_q, cap_v1_q;

    logic              busy, ld_en, first_slot, syn_zero;
    logic              go, srch_busy, srch_fin;
    logic [CODE_W-1:0] srch_phase;
    logic              hit;

    assign busy  = (st_q == ST_DECIDE) || (st_q == ST_SEARCH) || (st_q == ST_APPLY);
    assign ld_en = ld_valid && !busy;
    assign go    = (st_q == ST_DECIDE) && !syn_zero;

    ecc4_chk_bank #(.N_CHK(N_CHK), .CHK_W(CHK_W)) u_bank (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_val(ld_chk),
        .calc(calc_chk), .first_slot(first_slot), .syn_zero(syn_zero)
    );

    ecc4_search_model #(.LAT(SRCH_LAT)) u_search (
        .clk(clk), .rst(rst), .go(go),
        .busy(srch_busy), .fin(srch_fin), .phase(srch_phase)
    );

    ecc4_entry_apply #(.CHUNK_BYTES(CHUNK_BYTES), .OFF_BASE(OFF_BASE), .ADDR_W(ADDR_W)) u_apply (
        .active(st_q == ST_APPLY), .idx(idx_q),
        .a0(cap_a0_q), .a1(cap_a1_q), .v0(cap_v0_q), .v1(cap_v1_q),
        .hit(hit), .addr(buf_addr), .mask(buf_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            idx_q     <= '0;
            fix_q     <= '0;
            fld_q     <= '0;
            cap_unc_q <= 1'b0;
            cap_fld_q <= '0;
            cap_a0_q  <= '0;
            cap_a1_q  <= '0;
            cap_v0_q  <= '0;
            cap_v1_q  <= '0;
        end else begin
            case (st_q)
                ST_DECIDE: st_q <= syn_zero ? ST_CLEAN : ST_SEARCH;
                ST_SEARCH: begin
                    if (srch_fin) begin
                        if (cap_unc_q) begin
                            st_q <= ST_UNCORR;
                        end else begin
                            st_q  <= ST_APPLY;
                            idx_q <= '0;
                            fld_q <= cap_fld_q;
                        end
                    end
                end
                ST_APPLY: begin
                    if (hit) fix_q <= fix_q + 3'd1;
                    if (idx_q == cap_fld_q) st_q <= ST_FIXED;
                    else idx_q <= idx_q + 2'd1;
                end
                default: begin
                    if (start) begin
                        st_q      <= ST_DECIDE;
                        fix_q     <= '0;
                        fld_q     <= '0;
                        cap_unc_q <= loc_uncorr;
                        cap_fld_q <= loc_cnt_fld;
                        cap_a0_q  <= loc_addr_a;
                        cap_a1_q  <= loc_addr_b;
                        cap_v0_q  <= loc_val_a;
                        cap_v1_q  <= loc_val_b;
                    end else if (ld_valid && first_slot) begin
                        st_q  <= ST_IDLE;
                        fix_q <= '0;
                        fld_q <= '0;
                    end
                end
            endcase
        end
    end

    always_comb begin
        case (st_q)
            ST_DECIDE: st_code = CODE_SETTLED;
            ST_SEARCH: st_code = srch_phase;
            ST_UNCORR: st_code = CODE_UNCORR;
            ST_APPLY:  st_code = CODE_APPLY;
            ST_FIXED:  st_code = CODE_SETTLED;
            default:   st_code = CODE_CLEAN;
        endcase
    end

    assign done    = (st_q == ST_UNCORR) || (st_q == ST_FIXED) || (st_q == ST_CLEAN);
    assign fix_cnt = fix_q;
    assign err_fld = fld_q;
    assign buf_we  = hit;

    // R3: transient code right after an accepted start
    a_r3_start_shows_three: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (st_code == CODE_SETTLED && !done));
    // R9: a settled result never shows a working code
    a_r9_done_settled: assert property (@(posedge clk) disable iff (rst)
        done |-> (st_code < CODE_WORK));
    // R7: buffer writes only while applying entries
    a_r7_write_while_applying: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> (st_code == CODE_APPLY));
    // R11: start during the search does not disturb it
    a_r11_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SEARCH && srch_busy && !srch_fin && start) |=> (st_q == ST_SEARCH));
    // R10: first load of a new chunk clears the results
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !busy && first_slot && !start) |=> (!done && fix_cnt == 3'd0 && err_fld == 2'd0));
    // R5: uncorrectable outcome reports nothing corrected
    a_r5_uncorr_no_fix: assert property (@(posedge clk) disable iff (rst)
        (st_code == CODE_UNCORR) |-> (fix_cnt == 3'd0 && !buf_we));

endmodule

// File: tb/ecc4_fix_seq_test.sv
module ecc4_fix_seq_test;
    localparam int LAT = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_valid = 1'b0;
    logic [9:0]  ld_chk = '0;
    logic [79:0] calc_chk = '0;
    logic        start = 1'b0;
    logic        loc_uncorr = 1'b0;
    logic [1:0]  loc_cnt_fld = '0;
    logic [31:0] loc_addr_a = '0, loc_addr_b = '0, loc_val_a = '0, loc_val_b = '0;
    logic [3:0]  st_code;
    logic [1:0]  err_fld;
    logic [2:0]  fix_cnt;
    logic        done, buf_we;
    logic [8:0]  buf_addr;
    logic [7:0]  buf_mask;

    always #5 clk = ~clk;

    ecc4_fix_seq #(.SRCH_LAT(LAT)) uut (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_chk(ld_chk), .calc_chk(calc_chk),
        .start(start), .loc_uncorr(loc_uncorr), .loc_cnt_fld(loc_cnt_fld),
        .loc_addr_a(loc_addr_a), .loc_addr_b(loc_addr_b),
        .loc_val_a(loc_val_a), .loc_val_b(loc_val_b),
        .st_code(st_code), .err_fld(err_fld), .fix_cnt(fix_cnt), .done(done),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_mask(buf_mask)
    );

    int checks = 0, failures = 0, cycles = 0;
    logic [7:0] fbuf [512];

    // behavioural reference: 0 idle,1 decide,2 search,3 uncorr,4 apply,5 fixed,6 clean
    int mst = 0, mptr = 7, mcnt = 0, midx = 0, mfix = 0, mfld = 0;
    int mexp [8];
    int mcalc [8];
    int craw [4];
    int cval [4];
    int cfail = 0, cfld = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit m_zero();
        for (int k = 0; k < 8; k++) if (mexp[k] != mcalc[k]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit m_hit(input int i);
        int off = 519 - craw[i];
        return (off >= 0) && (off < 512);
    endfunction

    function automatic int m_code();
        case (mst)
            1: return 3;
            2: return 4 + (mcnt % 4);
            3: return 1;
            4: return 2;
            5: return 3;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mst = 0; mptr = 7; mcnt = 0; midx = 0; mfix = 0; mfld = 0;
            for (int k = 0; k < 8; k++) mexp[k] = 0;
        end else begin
            case (mst)
                1: begin
                    if (m_zero()) mst = 6;
                    else begin mst = 2; mcnt = 0; end
                end
                2: begin
                    if (mcnt == LAT - 1) begin
                        mcnt = 0;
                        if (cfail != 0) mst = 3;
                        else begin mst = 4; midx = 0; mfld = cfld; end
                    end else mcnt++;
                end
                4: begin
                    if (m_hit(midx)) mfix++;
                    if (midx == cfld) mst = 5; else midx++;
                end
                default: begin
                    if (ld_valid) begin
                        if (mptr == 7 && !start) begin mfix = 0; mfld = 0; mst = 0; end
                        mexp[mptr] = int'(ld_chk);
                        mptr = (mptr == 0) ? 7 : mptr - 1;
                    end
                    if (start) begin
                        mst = 1; mfix = 0; mfld = 0;
                        cfail = int'(loc_uncorr); cfld = int'(loc_cnt_fld);
                        craw[0] = int'(loc_addr_a[9:0]);  cval[0] = int'(loc_val_a[7:0]);
                        craw[1] = int'(loc_addr_a[25:16]); cval[1] = int'(loc_val_a[23:16]);
                        craw[2] = int'(loc_addr_b[9:0]);  cval[2] = int'(loc_val_b[7:0]);
                        craw[3] = int'(loc_addr_b[25:16]); cval[3] = int'(loc_val_b[23:16]);
                    end
                end
            endcase
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R4 st_code", int'(st_code), m_code());
            chk("R9 done", int'(done), (mst == 3 || mst == 5 || mst == 6) ? 1 : 0);
            chk("R9 fix_cnt", int'(fix_cnt), mfix);
            chk("R6 err_fld", int'(err_fld), mfld);
            chk("R7 buf_we", int'(buf_we), (mst == 4 && m_hit(midx)) ? 1 : 0);
            if (mst == 4 && m_hit(midx)) begin
                chk("R7 buf_addr", int'(buf_addr), 519 - craw[midx]);
                chk("R7 buf_mask", int'(buf_mask), cval[midx]);
            end
            if (buf_we) fbuf[buf_addr] = fbuf[buf_addr] ^ buf_mask;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            failures++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic load_chunk(input int bad_slot, input bit start_last);
        for (int k = 7; k >= 0; k--) begin
            ld_valid = 1'b1;
            ld_chk   = 10'(mcalc[k] ^ ((k == bad_slot) ? 1 : 0));
            start    = start_last && (k == 0);
            tick();
            if (k == 7) chk("R10 clear on first load", int'(done), 0);
        end
        ld_valid = 1'b0;
        start    = 1'b0;
    endtask

    task automatic kick();
        start = 1'b1;
        tick();
        start = 1'b0;
        chk("R3 transient code", int'(st_code), 3);
    endtask

    task automatic wait_done();
        int g = 0;
        while (!done && g < 100) begin tick(); g++; end
    endtask

    initial begin
        int nz;
        for (int i = 0; i < 512; i++) fbuf[i] = 8'h00;
        for (int k = 0; k < 8; k++) begin
            mcalc[k] = 256 + k * 37;
            calc_chk[k*10 +: 10] = 10'(mcalc[k]);
        end
        repeat (3) tick();
        rst = 1'b0;
        chk("R10 reset code", int'(st_code), 0);
        chk("R10 reset done", int'(done), 0);
        chk("R10 reset fix_cnt", int'(fix_cnt), 0);

        // clean chunk
        load_chunk(-1, 1'b0);
        kick();
        tick();
        chk("R2 zero syndrome code", int'(st_code), 0);
        chk("R2 zero syndrome done", int'(done), 1);

        // mismatch only in last value, start in same cycle
        loc_uncorr  = 1'b0;
        loc_cnt_fld = 2'd3;
        loc_addr_a  = {6'd0, 10'd8, 6'd0, 10'd519};
        loc_val_a   = {8'd0, 8'h81, 8'd0, 8'h5A};
        loc_addr_b  = {6'd0, 10'd700, 6'd0, 10'd7};
        loc_val_b   = {8'd0, 8'h11, 8'd0, 8'hFF};
        load_chunk(0, 1'b1);
        chk("R12 start with last load", int'(st_code), 3);
        tick();
        chk("R4 search begins", int'(st_code), 4);
        start = 1'b1; ld_valid = 1'b1; ld_chk = 10'h3FF;
        tick();
        start = 1'b0; ld_valid = 1'b0;
        chk("R11 start ignored in search", int'(st_code), 5);
        wait_done();
        chk("R9 settled code", int'(st_code), 3);
        chk("R9 corrected count", int'(fix_cnt), 2);
        chk("R6 count field", int'(err_fld), 3);
        chk("R7 byte 0", int'(fbuf[0]), 'h5A);
        chk("R6 byte 511 from upper half", int'(fbuf[511]), 'h81);
        nz = 0;
        for (int i = 0; i < 512; i++) if (fbuf[i] != 0) nz++;
        chk("R8 out of area skipped", nz, 2);

        // stray load during search must not have moved the pointer
        loc_uncorr = 1'b1;
        load_chunk(3, 1'b0);
        chk("R1 pointer kept", int'(fix_cnt), 0);
        kick();
        wait_done();
        chk("R5 uncorrectable code", int'(st_code), 1);
        chk("R5 no fix", int'(fix_cnt), 0);

        // restart from settled result without reload
        loc_uncorr  = 1'b0;
        loc_cnt_fld = 2'd0;
        loc_addr_a  = {6'd0, 10'd0, 6'd0, 10'd300};
        loc_val_a   = {8'd0, 8'd0, 8'd0, 8'h3C};
        kick();
        wait_done();
        chk("R11 restart corrected", int'(fix_cnt), 1);
        chk("R7 offset 219", int'(fbuf[219]), 'h3C);

        // every location outside the data area
        loc_cnt_fld = 2'd1;
        loc_addr_a  = {6'd0, 10'd1023, 6'd0, 10'd0};
        kick();
        wait_done();
        chk("R8 none corrected", int'(fix_cnt), 0);
        chk("R9 settled code", int'(st_code), 3);

        repeat (2) tick();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule